// File: doc/BRIEF.md
# DDS Serial Command Word Decoder

This block sits in front of a direct digital synthesis waveform core and turns a stream of 16-bit serial command words into the core's register state. A host drives chip select low, shifts words in most significant bit first on a serial clock, and each complete word is decoded by its top address bits into a write to one of five registers. These are a 16-bit control register, two 28-bit frequency tuning registers and two 12-bit phase offset registers.

A 28-bit tuning word does not fit in one command, so it travels as two 14-bit halves under the same address. When the control register selects full-width tuning, the two halves are paired: the first is parked in a holding register and the output register changes only when the second half arrives. This way the waveform core never runs on a half-updated frequency. When full-width tuning is off, each write replaces a single half, chosen by a control bit, and the replacement is visible at once. The serial inputs are synchronised to the system clock, so the serial clock must run well below the system clock.

Top module: `dds_cmd_decoder`

## Requirements
- R1: A word is framed by `spi_cs_n` low, with `spi_sclk` idling high. `spi_mosi` is sampled on each falling edge of `spi_sclk`, most significant bit first. The 16th falling edge completes a word, and further bits in the same frame start a new word from bit zero.
- R2: After reset, `ctrl_word` is 16'h2108 (full-width tuning, reset and divide-by-two set), and both frequency and both phase registers are zero.
- R3: A word with bits 15:14 = 00 loads the whole word into `ctrl_word` and leaves every other register unchanged. Control bit positions: 13 full-width tuning, 12 half select, 11 frequency select, 10 phase select, 9 pin/software select, 8 reset, 7 and 6 sleep, 5 square output enable, 4 sign/pin, 3 divide-by-two, 1 triangle mode.
- R4: A word with bits 15:13 = 110 loads bits 11:0 into phase register 0, and 111 loads them into phase register 1. Bit 12 is ignored, and the other registers are unchanged.
- R5: With control bit 13 set, the first write to a frequency address (bits 15:14 = 01 for register 0, 10 for register 1) holds bits 13:0 as the low half and leaves both frequency outputs unchanged. The next write to the same address commits {second bits 13:0, first bits 13:0}. Chip select may go high between the two halves.
- R6: In full-width mode, a frequency write to the other frequency address while a low half is held discards the held half and becomes the new low half. A control write also discards the held half. A phase write keeps it.
- R7: With control bit 13 clear, a frequency write replaces bits 13:0 of the addressed register when control bit 12 is 0, and bits 27:14 when it is 1. The other half keeps its value, and the change is visible without pairing.
- R8: If `spi_cs_n` rises before 16 falling edges of a word have been received, the partial word is discarded and no register changes. The next frame starts at bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle high, data taken on falling edge |
| spi_mosi | input | 1 | Serial data in, most significant bit first |
| ctrl_word | output | 16 | Current control register |
| freq0_word | output | 28 | Frequency tuning register 0 |
| freq1_word | output | 28 | Frequency tuning register 1 |
| phase0_word | output | 12 | Phase offset register 0 |
| phase1_word | output | 12 | Phase offset register 1 |

## Verification
A wrong bit count or a shift register that is out of step shows as a register loaded with a shifted value, or as a write that lands in the wrong destination. This becomes visible about five system clocks after the falling edge that should have completed the word. A stale or misdirected held low half stays hidden until the next frequency write in full-width mode. It then surfaces as a tuning word whose low 14 bits do not match, or as an output that moves on the first half. For that reason the bench runs pair sequences that are interrupted by the other address, by control writes and by phase writes. A partial frame that is not discarded shows as a register change, or as the following complete word being decoded with the wrong alignment.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;

  localparam int unsigned CMD_W     = 16;
  localparam int unsigned TUNE_W    = 28;
  localparam int unsigned HALF_W    = TUNE_W / 2;
  localparam int unsigned PHASE_W   = 12;

  localparam int unsigned CB_FULLW  = 13;
  localparam int unsigned CB_HALF   = 12;

  localparam logic [CMD_W-1:0] CTRL_POR = 16'h2108;

  typedef enum logic [2:0] {
    DST_CTRL = 3'd0,
    DST_F0   = 3'd1,
    DST_F1   = 3'd2,
    DST_P0   = 3'd3,
    DST_P1   = 3'd4
  } dst_e;

  function automatic dst_e decode_dst(input logic [CMD_W-1:0] w);
    dst_e r;
    case (w[CMD_W-1 -: 2])
      2'b00:   r = DST_CTRL;
      2'b01:   r = DST_F0;
      2'b10:   r = DST_F1;
      default: r = w[CMD_W-3] ? DST_P1 : DST_P0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dds_in_sync.sv
module dds_in_sync #(
  parameter int unsigned     N       = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_word_rx.sv
module spi_word_rx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);

  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_q, sclk_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              fall;
  logic              word_en;

  assign fall = sclk_q & ~sclk_s;

  always_comb begin
    sclk_d  = sclk_s;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    vld_d   = 1'b0;
    word_d  = word_q;
    word_en = 1'b0;
    if (cs_n_s) begin
      cnt_d = '0;
    end else if (fall) begin
      sh_d = {sh_q[WORD_W-2:0], mosi_s};
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        vld_d   = 1'b1;
        word_en = 1'b1;
        word_d  = {sh_q[WORD_W-2:0], mosi_s};
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      sclk_q <= sclk_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      if (word_en) word_q <= word_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = word_q;

  // a deasserted select leaves no partial count and no word behind (R8)
  assert_cs_clears_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt_q == '0) && !vld_q);

  // each completed word is announced by a single-cycle pulse (R1)
  assert_word_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/cmd_reg_file.sv
module cmd_reg_file
  import dds_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_vld,
  input  logic [CMD_W-1:0]   word,
  output logic [CMD_W-1:0]   ctrl,
  output logic [TUNE_W-1:0]  freq0,
  output logic [TUNE_W-1:0]  freq1,
  output logic [PHASE_W-1:0] phase0,
  output logic [PHASE_W-1:0] phase1
);

  localparam int unsigned NCH = 2;

  dst_e                dst;
  logic                ch;
  logic [HALF_W-1:0]   half_data;

  logic [CMD_W-1:0]    ctrl_q, ctrl_d;
  logic [TUNE_W-1:0]   freq_q  [NCH];
  logic [TUNE_W-1:0]   freq_d  [NCH];
  logic [PHASE_W-1:0]  phase_q [NCH];
  logic [PHASE_W-1:0]  phase_d [NCH];
  logic                pend_q, pend_d;
  logic                pch_q, pch_d;
  logic [HALF_W-1:0]   plo_q, plo_d;

  assign dst       = decode_dst(word);
  assign half_data = word[HALF_W-1:0];
  assign ch        = (dst == DST_F1) || (dst == DST_P1);

  always_comb begin
    ctrl_d  = ctrl_q;
    freq_d  = freq_q;
    phase_d = phase_q;
    pend_d  = pend_q;
    pch_d   = pch_q;
    plo_d   = plo_q;
    if (word_vld) begin
      unique case (dst)
        DST_CTRL: begin
          ctrl_d = word;
          pend_d = 1'b0;
        end
        DST_F0, DST_F1: begin
          if (ctrl_q[CB_FULLW]) begin
            if (pend_q && (pch_q == ch)) begin
              freq_d[ch] = {half_data, plo_q};
              pend_d     = 1'b0;
            end else begin
              pend_d = 1'b1;
              pch_d  = ch;
              plo_d  = half_data;
            end
          end else if (ctrl_q[CB_HALF]) begin
            freq_d[ch][TUNE_W-1:HALF_W] = half_data;
          end else begin
            freq_d[ch][HALF_W-1:0] = half_data;
          end
        end
        default: begin
          phase_d[ch] = word[PHASE_W-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_POR;
      pend_q <= 1'b0;
      pch_q  <= 1'b0;
      plo_q  <= '0;
    end else if (word_vld) begin
      ctrl_q <= ctrl_d;
      pend_q <= pend_d;
      pch_q  <= pch_d;
      plo_q  <= plo_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        freq_q[c]  <= '0;
        phase_q[c] <= '0;
      end else if (word_vld) begin
        freq_q[c]  <= freq_d[c];
        phase_q[c] <= phase_d[c];
      end
    end
  end

  assign ctrl   = ctrl_q;
  assign freq0  = freq_q[0];
  assign freq1  = freq_q[1];
  assign phase0 = phase_q[0];
  assign phase1 = phase_q[1];

  // control register moves only on a control-addressed word (R3)
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && dst == DST_CTRL) |=> $stable(ctrl_q));

  // phase registers move only on a phase-addressed word (R4)
  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && (dst == DST_P0 || dst == DST_P1)) |=> $stable(phase_q[0]) && $stable(phase_q[1]));

  // in full-width mode a write with nothing held never reaches the outputs (R5)
  assert_first_half_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && ctrl_q[CB_FULLW] && !pend_q) |=> $stable(freq_q[0]) && $stable(freq_q[1]));

  // a control write leaves no held half behind (R6)
  assert_ctrl_drops_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && dst == DST_CTRL) |=> !pend_q);

endmodule

// File: rtl/dds_cmd_decoder.sv
module dds_cmd_decoder
  import dds_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_cs_n,
  input  logic               spi_sclk,
  input  logic               spi_mosi,
  output logic [CMD_W-1:0]   ctrl_word,
  output logic [TUNE_W-1:0]  freq0_word,
  output logic [TUNE_W-1:0]  freq1_word,
  output logic [PHASE_W-1:0] phase0_word,
  output logic [PHASE_W-1:0] phase1_word
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic [2:0]       pins_s;
  logic             word_vld;
  logic [CMD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  dds_in_sync #(
    .N       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({spi_cs_n, spi_sclk, spi_mosi}),
    .q     (pins_s)
  );

  spi_word_rx #(
    .WORD_W (CMD_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_n_s   (pins_s[2]),
    .sclk_s   (pins_s[1]),
    .mosi_s   (pins_s[0]),
    .word_vld (word_vld),
    .word     (word)
  );

  cmd_reg_file u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .word_vld (word_vld),
    .word     (word),
    .ctrl     (ctrl_word),
    .freq0    (freq0_word),
    .freq1    (freq1_word),
    .phase0   (phase0_word),
    .phase1   (phase1_word)
  );

endmodule

// File: tb/dds_cmd_decoder_tb_top.sv
module dds_cmd_decoder_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic        sclk;
  logic        mosi;
  logic [15:0] ctrl_o;
  logic [27:0] f0_o, f1_o;
  logic [11:0] p0_o, p1_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] c;
    logic [27:0] f0;
    logic [27:0] f1;
    logic [11:0] p0;
    logic [11:0] p1;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  logic [15:0] m_ctrl;
  logic [27:0] m_f [2];
  logic [11:0] m_p [2];
  bit          m_hold;
  bit          m_hold_ch;
  logic [13:0] m_lo;

  dds_cmd_decoder dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (cs_n),
    .spi_sclk    (sclk),
    .spi_mosi    (mosi),
    .ctrl_word   (ctrl_o),
    .freq0_word  (f0_o),
    .freq1_word  (f1_o),
    .phase0_word (p0_o),
    .phase1_word (p1_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected-state model written from the requirement text
  task automatic model_word(input logic [15:0] w);
    bit c;
    if (w[15:14] == 2'b00) begin           // R3 control, R6 drop held half
      m_ctrl = w;
      m_hold = 0;
    end else if (w[15:14] != 2'b11) begin  // frequency address
      c = w[15];
      if (m_ctrl[13]) begin
        if (m_hold && m_hold_ch == c) begin
          m_f[c] = {w[13:0], m_lo};
          m_hold = 0;
        end else begin
          m_hold = 1; m_hold_ch = c; m_lo = w[13:0];
        end
      end else if (m_ctrl[12]) m_f[c][27:14] = w[13:0];
      else                     m_f[c][13:0]  = w[13:0];
    end else begin                          // R4 phase
      m_p[w[13]] = w[11:0];
    end
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    e.c = m_ctrl; e.f0 = m_f[0]; e.f1 = m_f[1];
    e.p0 = m_p[0]; e.p1 = m_p[1]; e.tag = tag;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift the top n bits of a 32-bit vector in one frame
  task automatic send_bits(input logic [31:0] bits, input int n);
    cs_n = 1'b0;
    clks(4);
    for (int i = 0; i < n; i++) begin
      mosi = bits[31-i];
      clks(2);
      sclk = 1'b0;
      clks(4);
      sclk = 1'b1;
      clks(2);
    end
    clks(4);
    cs_n = 1'b1;
    clks(10);
  endtask

  task automatic send_word(input logic [15:0] w);
    send_bits({w, 16'h0000}, 16);
    model_word(w);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (ctrl_o !== e.c) begin
        fails++;
        $display("FAIL %s ctrl: actual=%h expected=%h", e.tag, ctrl_o, e.c);
      end
      checks++;
      if (f0_o !== e.f0) begin
        fails++;
        $display("FAIL %s freq0: actual=%h expected=%h", e.tag, f0_o, e.f0);
      end
      checks++;
      if (f1_o !== e.f1) begin
        fails++;
        $display("FAIL %s freq1: actual=%h expected=%h", e.tag, f1_o, e.f1);
      end
      checks++;
      if (p0_o !== e.p0) begin
        fails++;
        $display("FAIL %s phase0: actual=%h expected=%h", e.tag, p0_o, e.p0);
      end
      checks++;
      if (p1_o !== e.p1) begin
        fails++;
        $display("FAIL %s phase1: actual=%h expected=%h", e.tag, p1_o, e.p1);
      end
    end
  end

  initial begin
    cs_n = 1'b1; sclk = 1'b1; mosi = 1'b0; rst_n = 1'b0;
    m_ctrl = 16'h2108; m_f[0] = '0; m_f[1] = '0; m_p[0] = '0; m_p[1] = '0;
    m_hold = 0; m_hold_ch = 0; m_lo = '0;
    clks(5);
    rst_n = 1'b1;
    clks(5);
    expect_now("R2 reset values");

    // control register patterns (R3)
    send_word(16'h0000); expect_now("R3 control clear");
    send_word(16'h1555); expect_now("R3 control pattern 1555");

    // half-select mode (R7): bit13 clear, bit12 set -> high half
    send_word(16'h4ABC); expect_now("R7 freq0 high half");
    send_word(16'h0000);
    send_word(16'h5234); expect_now("R7 freq0 low half keeps high");
    send_word(16'h0000);
    send_word(16'hBFFF); expect_now("R7 freq1 low half");
    send_word(16'h1000);
    send_word(16'h8001); expect_now("R7 freq1 high half keeps low");

    // full-width pairing (R5)
    send_word(16'h2AAA); expect_now("R3 control pattern 2AAA");
    send_word(16'h4111); expect_now("R5 first half hidden");
    send_word(16'h6222); expect_now("R5 pair committed to freq0");

    // pairing interrupted (R6)
    send_word(16'h4005);
    send_word(16'h8007); expect_now("R6 other address restarts pair");
    send_word(16'h8009); expect_now("R6 freq1 pair after restart");
    send_word(16'h4001);
    send_word(16'h2000); expect_now("R6 control write mid pair");
    send_word(16'h4002); expect_now("R6 held half was dropped");
    send_word(16'h4003); expect_now("R6 freq0 fresh pair");
    send_word(16'h8010);
    send_word(16'hC123); expect_now("R6 phase write during pair");
    send_word(16'h8020); expect_now("R6 held half survives phase write");

    // phase registers (R4)
    send_word(16'hD456); expect_now("R4 phase0 bit12 ignored");
    send_word(16'hEFFF); expect_now("R4 phase1 all ones");

    // partial frame discarded (R8)
    send_bits({16'hC0AA, 16'h0000}, 10);
    expect_now("R8 partial word discarded");
    send_bits({16'h4123, 16'h0000}, 15);
    expect_now("R8 fifteen bits discarded");
    send_word(16'hE00F); expect_now("R8 next frame aligned");

    // two words in one frame (R1)
    send_bits({16'hC001, 16'hE002}, 32);
    model_word(16'hC001);
    model_word(16'hE002);
    expect_now("R1 back-to-back words in one frame");

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule